// File: doc/BRIEF.md
# Register Pool Partition Allocator

This block manages the physical register pool of one multiprocessor. When a thread block is launched, the scheduler asks for registers by giving the thread count and the registers each thread needs. The block computes the size as their product and searches the pool for a free contiguous run of that size, using first-fit. It then either grants a base and a length held in a numbered block slot, or refuses the whole request. Parts of a request are never granted. When a block retires, releasing its slot returns the range to free space. Because free space is defined by the gaps between resident ranges, the freed range joins its free neighbours at once.

Each operation uses a request/ready handshake and finishes a fixed two edges after it is accepted, with a one-cycle response pulse. A separate lookup port takes a slot, a thread index and a register index. It returns the physical register address and a violation flag. The flag stops a thread from reaching registers outside its own share of its own block's range. Because a range belongs to one slot only, the number of resident blocks drops in whole-block steps as per-thread register use grows.

Top module: `regpart_alloc`

## Requirements
- R1: After a synchronous reset, req_ready is 1 and rsp_valid is 0. Every slot is free, so a lookup of any slot reports a violation.
- R2: An operation is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 0 in the following cycle. rsp_valid is 1 for exactly one cycle, after the second rising edge counted from acceptance, and req_ready is 1 again at the same time.
- R3: An allocation (req_op = 0) of threads × regs-per-thread registers is granted with rsp_len equal to that product. rsp_base is the lowest address that starts a free contiguous run of at least that size, and rsp_slot is the lowest-numbered free slot.
- R4: The ranges held by valid slots never overlap and always lie inside the pool of POOL_REGS (8192) registers.
- R5: An allocation with no free contiguous run large enough is refused with rsp_reject = 1 and rsp_ok = 0. Nothing is granted and the slot table is unchanged.
- R6: An allocation is refused when all SLOTS (8) slots are in use.
- R7: An allocation whose thread count or regs-per-thread is zero is refused.
- R8: A release (req_op = 1) of a valid slot answers rsp_ok and frees the slot. Its range joins adjacent free space, so a later request can use the whole merged run.
- R9: A release of a slot that is not valid is refused and has no effect.
- R10: One cycle after lk_valid, lk_out_valid is 1 and lk_addr = base + thread × regs-per-thread + reg of the addressed slot.
- R11: lk_violation is 1 and lk_addr is 0 when the slot is free, the register index is not below the slot's regs-per-thread, or the thread index is not below the slot's thread count.
- R12: With 256 threads at 10 registers each, three blocks are granted and a fourth is refused. With 256 threads at 11 registers each, two blocks are granted and a third is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Allocator idle, request can be accepted |
| req_op | input | 1 | 0 allocate, 1 release |
| req_threads | input | THR_W (10) | Thread count of the block |
| req_rpt | input | RPT_W (6) | Registers per thread |
| req_slot | input | SLOT_W (3) | Slot to release |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_ok | output | 1 | Operation done |
| rsp_reject | output | 1 | Operation refused |
| rsp_slot | output | SLOT_W (3) | Slot granted or released |
| rsp_base | output | ADDR_W (14) | Base of the range |
| rsp_len | output | ADDR_W (14) | Length of the range |
| lk_valid | input | 1 | Lookup request |
| lk_slot | input | SLOT_W (3) | Slot of the accessing block |
| lk_thread | input | THR_W (10) | Thread index inside the block |
| lk_reg | input | RPT_W (6) | Register index inside the thread |
| lk_out_valid | output | 1 | Lookup result valid |
| lk_addr | output | ADDR_W (14) | Physical register address |
| lk_violation | output | 1 | Access outside the thread's share |

## Verification
A slot table that is wrong inside shows up on the next allocation response. If a base or length is stale, the first-fit base moves or a request is refused that should be granted. If a valid bit is stuck, the granted slot number changes or a full-table refusal appears early. Both can be seen two edges after the request. Lookups expose the stored thread count, regs-per-thread and base one cycle after they are issued. Probing the boundary indices right after a grant or a release therefore shows a wrong field within a cycle.

// File: rtl/regpart_pkg.sv
package regpart_pkg;
  typedef enum logic {
    OP_ALLOC   = 1'b0,
    OP_RELEASE = 1'b1
  } regpart_op_e;
endpackage

// File: rtl/regpart_fit.sv
// First-fit search: candidates are address 0 and the end of every resident range.
module regpart_fit #(
  parameter int SLOTS     = 8,
  parameter int ADDR_W    = 14,
  parameter int NEED_W    = 16,
  parameter int POOL_REGS = 8192
) (
  input  logic [SLOTS-1:0]             vld_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0] base_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0] len_i,
  input  logic [NEED_W-1:0]            need_i,
  output logic                         found_o,
  output logic [ADDR_W-1:0]            base_o
);
  localparam int EXT_W = ((NEED_W > ADDR_W) ? NEED_W : ADDR_W) + 1;
  localparam int NCAND = SLOTS + 1;

  logic [NCAND-1:0][EXT_W-1:0] cand_lo;
  logic [NCAND-1:0]            cand_en;
  logic [NCAND-1:0]            cand_hit;
  logic [EXT_W-1:0]            best;

  assign cand_lo[0] = '0;
  assign cand_en[0] = 1'b1;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cand
    assign cand_lo[i+1] = EXT_W'(base_i[i]) + EXT_W'(len_i[i]);
    assign cand_en[i+1] = vld_i[i];
  end

  for (genvar k = 0; k < NCAND; k++) begin : g_hit
    logic [EXT_W-1:0] hi;
    logic             clash;
    assign hi = cand_lo[k] + EXT_W'(need_i);
    always_comb begin
      clash = 1'b0;
      for (int j = 0; j < SLOTS; j++) begin
        if (vld_i[j] && (cand_lo[k] < EXT_W'(base_i[j]) + EXT_W'(len_i[j]))
            && (EXT_W'(base_i[j]) < hi))
          clash = 1'b1;
      end
    end
    assign cand_hit[k] = cand_en[k] && (hi <= EXT_W'(POOL_REGS)) && !clash;
  end

  always_comb begin
    found_o = 1'b0;
    best    = '0;
    for (int k = 0; k < NCAND; k++) begin
      if (cand_hit[k] && (!found_o || cand_lo[k] < best)) begin
        found_o = 1'b1;
        best    = cand_lo[k];
      end
    end
  end

  assign base_o = best[ADDR_W-1:0];
endmodule

// File: rtl/regpart_lookup.sv
// Registered translation of (slot, thread, reg) to a physical register address.
module regpart_lookup #(
  parameter int SLOTS     = 8,
  parameter int SLOT_W    = 3,
  parameter int ADDR_W    = 14,
  parameter int THR_W     = 10,
  parameter int RPT_W     = 6,
  parameter int POOL_REGS = 8192
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [SLOTS-1:0]             vld_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0] base_i,
  input  logic [SLOTS-1:0][THR_W-1:0]  thr_i,
  input  logic [SLOTS-1:0][RPT_W-1:0]  rpt_i,
  input  logic                         lk_valid,
  input  logic [SLOT_W-1:0]            lk_slot,
  input  logic [THR_W-1:0]             lk_thread,
  input  logic [RPT_W-1:0]             lk_reg,
  output logic                         lk_out_valid,
  output logic [ADDR_W-1:0]            lk_addr,
  output logic                         lk_violation
);
  localparam int LW = ((THR_W + RPT_W > ADDR_W) ? THR_W + RPT_W : ADDR_W) + 1;

  logic          bad;
  logic [LW-1:0] phys;

  assign bad  = !vld_i[lk_slot] || (lk_reg >= rpt_i[lk_slot]) || (lk_thread >= thr_i[lk_slot]);
  assign phys = LW'(base_i[lk_slot]) + LW'(lk_thread) * LW'(rpt_i[lk_slot]) + LW'(lk_reg);

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_out_valid <= 1'b0;
      lk_addr      <= '0;
      lk_violation <= 1'b0;
    end else begin
      lk_out_valid <= lk_valid;
      if (lk_valid) begin
        lk_violation <= bad;
        lk_addr      <= bad ? '0 : phys[ADDR_W-1:0];
      end
    end
  end

  p_lookup_in_pool_r10: assert property (@(posedge clk) disable iff (rst)
    (lk_out_valid && !lk_violation) |-> (LW'(lk_addr) < LW'(POOL_REGS)));
  p_viol_zero_addr_r11: assert property (@(posedge clk) disable iff (rst)
    (lk_out_valid && lk_violation) |-> (lk_addr == '0));
endmodule

// File: rtl/regpart_alloc.sv
module regpart_alloc #(
  parameter int POOL_REGS   = 8192,
  parameter int SLOTS       = 8,
  parameter int MAX_THREADS = 512,
  parameter int MAX_RPT     = 32
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_op,
  input  logic [$clog2(MAX_THREADS+1)-1:0]       req_threads,
  input  logic [$clog2(MAX_RPT+1)-1:0]           req_rpt,
  input  logic [$clog2(SLOTS)-1:0]               req_slot,
  output logic                                   rsp_valid,
  output logic                                   rsp_ok,
  output logic                                   rsp_reject,
  output logic [$clog2(SLOTS)-1:0]               rsp_slot,
  output logic [$clog2(POOL_REGS+1)-1:0]         rsp_base,
  output logic [$clog2(POOL_REGS+1)-1:0]         rsp_len,
  input  logic                                   lk_valid,
  input  logic [$clog2(SLOTS)-1:0]               lk_slot,
  input  logic [$clog2(MAX_THREADS+1)-1:0]       lk_thread,
  input  logic [$clog2(MAX_RPT+1)-1:0]           lk_reg,
  output logic                                   lk_out_valid,
  output logic [$clog2(POOL_REGS+1)-1:0]         lk_addr,
  output logic                                   lk_violation
);
  import regpart_pkg::*;

  localparam int THR_W  = $clog2(MAX_THREADS + 1);
  localparam int RPT_W  = $clog2(MAX_RPT + 1);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int ADDR_W = $clog2(POOL_REGS + 1);
  localparam int NEED_W = THR_W + RPT_W;
  localparam int EXT_W  = ((NEED_W > ADDR_W) ? NEED_W : ADDR_W) + 1;

  logic [SLOTS-1:0]             slot_vld;
  logic [SLOTS-1:0][ADDR_W-1:0] slot_base;
  logic [SLOTS-1:0][ADDR_W-1:0] slot_len;
  logic [SLOTS-1:0][THR_W-1:0]  slot_thr;
  logic [SLOTS-1:0][RPT_W-1:0]  slot_rpt;

  logic              busy;
  regpart_op_e       op_q;
  logic [THR_W-1:0]  thr_q;
  logic [RPT_W-1:0]  rpt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [NEED_W-1:0] need_q;

  logic              fit_found;
  logic [ADDR_W-1:0] fit_base;
  logic              free_any;
  logic [SLOT_W-1:0] free_idx;

  assign req_ready = !busy;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        free_any = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
  end

  regpart_fit #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .NEED_W(NEED_W), .POOL_REGS(POOL_REGS)
  ) u_fit (
    .vld_i(slot_vld), .base_i(slot_base), .len_i(slot_len), .need_i(need_q),
    .found_o(fit_found), .base_o(fit_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      op_q       <= OP_ALLOC;
      thr_q      <= '0;
      rpt_q      <= '0;
      slot_q     <= '0;
      need_q     <= '0;
      slot_vld   <= '0;
      slot_base  <= '0;
      slot_len   <= '0;
      slot_thr   <= '0;
      slot_rpt   <= '0;
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_reject <= 1'b0;
      rsp_slot   <= '0;
      rsp_base   <= '0;
      rsp_len    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          op_q   <= regpart_op_e'(req_op);
          thr_q  <= req_threads;
          rpt_q  <= req_rpt;
          slot_q <= req_slot;
          need_q <= NEED_W'(req_threads) * NEED_W'(req_rpt);
        end
      end else begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        if (op_q == OP_ALLOC) begin
          if (thr_q != '0 && rpt_q != '0 && free_any && fit_found) begin
            slot_vld[free_idx]  <= 1'b1;
            slot_base[free_idx] <= fit_base;
            slot_len[free_idx]  <= need_q[ADDR_W-1:0];
            slot_thr[free_idx]  <= thr_q;
            slot_rpt[free_idx]  <= rpt_q;
            rsp_ok     <= 1'b1;
            rsp_reject <= 1'b0;
            rsp_slot   <= free_idx;
            rsp_base   <= fit_base;
            rsp_len    <= need_q[ADDR_W-1:0];
          end else begin
            rsp_ok     <= 1'b0;
            rsp_reject <= 1'b1;
            rsp_slot   <= '0;
            rsp_base   <= '0;
            rsp_len    <= '0;
          end
        end else begin
          rsp_slot <= slot_q;
          if (slot_vld[slot_q]) begin
            slot_vld[slot_q] <= 1'b0;
            rsp_ok     <= 1'b1;
            rsp_reject <= 1'b0;
            rsp_base   <= slot_base[slot_q];
            rsp_len    <= slot_len[slot_q];
          end else begin
            rsp_ok     <= 1'b0;
            rsp_reject <= 1'b1;
            rsp_base   <= '0;
            rsp_len    <= '0;
          end
        end
      end
    end
  end

  regpart_lookup #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .THR_W(THR_W), .RPT_W(RPT_W),
    .POOL_REGS(POOL_REGS)
  ) u_lookup (
    .clk(clk), .rst(rst),
    .vld_i(slot_vld), .base_i(slot_base), .thr_i(slot_thr), .rpt_i(slot_rpt),
    .lk_valid(lk_valid), .lk_slot(lk_slot), .lk_thread(lk_thread), .lk_reg(lk_reg),
    .lk_out_valid(lk_out_valid), .lk_addr(lk_addr), .lk_violation(lk_violation)
  );

  p_ready_drops_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  p_ok_or_reject_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_ok != rsp_reject));
  p_grant_in_pool_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ok) |-> (EXT_W'(rsp_base) + EXT_W'(rsp_len) <= EXT_W'(POOL_REGS)));
  p_zero_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == OP_ALLOC && (req_threads == '0 || req_rpt == '0))
    |=> ##1 (rsp_valid && rsp_reject));

  for (genvar a = 0; a < SLOTS; a++) begin : g_pa
    for (genvar b = a + 1; b < SLOTS; b++) begin : g_pb
      p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        (slot_vld[a] && slot_vld[b]) |->
          ((EXT_W'(slot_base[a]) + EXT_W'(slot_len[a]) <= EXT_W'(slot_base[b])) ||
           (EXT_W'(slot_base[b]) + EXT_W'(slot_len[b]) <= EXT_W'(slot_base[a]))));
    end
  end
endmodule

// File: tb/test_regpart_alloc.sv
module test_regpart_alloc;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic        req_op;
  logic [9:0]  req_threads;
  logic [5:0]  req_rpt;
  logic [2:0]  req_slot;
  logic        rsp_valid, rsp_ok, rsp_reject;
  logic [2:0]  rsp_slot;
  logic [13:0] rsp_base, rsp_len;
  logic        lk_valid;
  logic [2:0]  lk_slot;
  logic [9:0]  lk_thread;
  logic [5:0]  lk_reg;
  logic        lk_out_valid;
  logic [13:0] lk_addr;
  logic        lk_violation;

  int n_chk = 0;
  int n_fail = 0;
  logic        r_ok, r_rej, r_vld, r_rdy_mid;
  logic [2:0]  r_slot;
  logic [13:0] r_base, r_len;

  always #2.5 clk = ~clk;

  regpart_alloc i_regpart_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_threads(req_threads), .req_rpt(req_rpt), .req_slot(req_slot),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_reject(rsp_reject), .rsp_slot(rsp_slot),
    .rsp_base(rsp_base), .rsp_len(rsp_len), .lk_valid(lk_valid), .lk_slot(lk_slot),
    .lk_thread(lk_thread), .lk_reg(lk_reg), .lk_out_valid(lk_out_valid),
    .lk_addr(lk_addr), .lk_violation(lk_violation)
  );

  task automatic chk(input logic cond, input string what, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic op(input logic o, input int thr, input int rpt, input int slot);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = o;
    req_threads = 10'(thr); req_rpt = 6'(rpt); req_slot = 3'(slot);
    @(negedge clk);
    req_valid = 1'b0;
    r_rdy_mid = req_ready;
    @(negedge clk);
    r_vld = rsp_valid; r_ok = rsp_ok; r_rej = rsp_reject;
    r_slot = rsp_slot; r_base = rsp_base; r_len = rsp_len;
    chk(r_rdy_mid == 1'b0, "R2 ready low while busy", r_rdy_mid, 0);
    chk(r_vld == 1'b1, "R2 response pulse", r_vld, 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 response one cycle", rsp_valid, 0);
  endtask

  task automatic alloc_ok(input int thr, input int rpt, input int slot, input int base, input string tag);
    op(1'b0, thr, rpt, 0);
    chk(r_ok && !r_rej, {tag, " grant"}, r_ok, 1);
    chk(r_slot == 3'(slot), {tag, " slot"}, r_slot, slot);
    chk(r_base == 14'(base), {tag, " base"}, r_base, base);
    chk(r_len == 14'(thr * rpt), {tag, " len"}, r_len, thr * rpt);
  endtask

  task automatic alloc_rej(input int thr, input int rpt, input string tag);
    op(1'b0, thr, rpt, 0);
    chk(r_rej && !r_ok, {tag, " reject"}, r_rej, 1);
  endtask

  task automatic rel(input int slot, input logic exp_ok, input string tag);
    op(1'b1, 0, 0, slot);
    chk(r_ok == exp_ok && r_rej == !exp_ok, {tag, " release"}, r_ok, exp_ok);
  endtask

  task automatic look(input int slot, input int thr, input int rg, input logic exp_v,
                      input int exp_a, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_slot = 3'(slot); lk_thread = 10'(thr); lk_reg = 6'(rg);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(lk_out_valid == 1'b1, {tag, " lookup valid"}, lk_out_valid, 1);
    chk(lk_violation == exp_v, {tag, " violation"}, lk_violation, exp_v);
    chk(lk_addr == 14'(exp_a), {tag, " address"}, lk_addr, exp_a);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    look(0, 0, 0, 1'b1, 0, "R1 slot0 free");
    look(7, 0, 0, 1'b1, 0, "R1 slot7 free");
  endtask

  task automatic t_capacity;
    alloc_ok(256, 10, 0, 0, "R12 10rpt first");
    alloc_ok(256, 10, 1, 2560, "R12 10rpt second");
    alloc_ok(256, 10, 2, 5120, "R12 10rpt third");
    alloc_rej(256, 10, "R12 10rpt fourth");
    rel(0, 1'b1, "R8"); rel(1, 1'b1, "R8"); rel(2, 1'b1, "R8");
    alloc_ok(256, 11, 0, 0, "R12 11rpt first");
    alloc_ok(256, 11, 1, 2816, "R12 11rpt second");
    alloc_rej(256, 11, "R12 11rpt third");
    rel(0, 1'b1, "R8"); rel(1, 1'b1, "R8");
  endtask

  task automatic t_zero;
    alloc_rej(0, 10, "R7 zero threads");
    alloc_rej(16, 0, "R7 zero regs");
    alloc_ok(1, 1, 0, 0, "R7 table untouched");
    rel(0, 1'b1, "R8");
  endtask

  task automatic t_first_fit;
    alloc_ok(100, 10, 0, 0, "R3 A");
    alloc_ok(100, 10, 1, 1000, "R3 B");
    alloc_ok(100, 10, 2, 2000, "R3 C");
    rel(1, 1'b1, "R8 hole");
    alloc_ok(50, 10, 1, 1000, "R3 reuse hole lowest slot");
    rel(1, 1'b1, "R8"); rel(0, 1'b1, "R8");
    alloc_ok(200, 10, 0, 0, "R8 merged run");
    rel(5, 1'b0, "R9 free slot");
    alloc_ok(1, 1, 1, 3000, "R9 no side effect");
    rel(0, 1'b1, "R8"); rel(1, 1'b1, "R8"); rel(2, 1'b1, "R8");
  endtask

  task automatic t_slots_full;
    for (int i = 0; i < 8; i++) alloc_ok(1, 1, i, i, "R6 fill");
    alloc_rej(1, 1, "R6 all slots used");
    for (int i = 0; i < 8; i++) rel(i, 1'b1, "R8");
  endtask

  task automatic t_no_fit;
    alloc_ok(512, 8, 0, 0, "R5 low half");
    alloc_ok(512, 8, 1, 4096, "R5 high half");
    rel(0, 1'b1, "R8");
    alloc_rej(241, 17, "R5 one too many");
    alloc_ok(512, 8, 0, 0, "R5 exact fit");
    rel(0, 1'b1, "R8"); rel(1, 1'b1, "R8");
    look(0, 0, 0, 1'b1, 0, "R8 released slot unreachable");
  endtask

  task automatic t_lookup;
    alloc_ok(256, 10, 0, 0, "R10 block0");
    alloc_ok(64, 4, 1, 2560, "R10 block1");
    look(1, 3, 2, 1'b0, 2574, "R10 inner");
    look(1, 63, 3, 1'b0, 2815, "R10 last register");
    look(0, 255, 9, 1'b0, 2559, "R10 block0 last");
    look(1, 64, 0, 1'b1, 0, "R11 thread past count");
    look(1, 0, 4, 1'b1, 0, "R11 reg past share");
    look(6, 0, 0, 1'b1, 0, "R11 free slot");
    rel(0, 1'b1, "R8"); rel(1, 1'b1, "R8");
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = 1'b0; req_threads = '0; req_rpt = '0;
    req_slot = '0; lk_valid = 1'b0; lk_slot = '0; lk_thread = '0; lk_reg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_capacity;
    t_zero;
    t_first_fit;
    t_slots_full;
    t_no_fit;
    t_lookup;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule